// File: doc/BRIEF.md
# Nibble-Packed Pixel Write Unit

This unit sits between a processor bus and a byte-wide memory that stores two 4-bit pixels in each byte. To the processor, every pixel is a separate byte address. A byte access reaches one pixel: the upper nibble at even addresses and the lower nibble at odd addresses. A word access reaches both pixels of one stored byte at once. Reads return pixels zero-extended, so the processor never sees the packing.

Every write is a read-modify-write. In the request cycle the memory byte is read. In the next cycle the merged byte is written back. A 2-bit priority mode decides which nibbles are replaced:
- a plain write always replaces the nibble;
- an underwrite fills only nibbles that are still zero;
- an overwrite ignores zero (transparent) source pixels.

This lets a drawing engine layer sprites in front of or behind existing pixels without reading them first.

Top module: `nibble_pix_rmw`

## Requirements
- R1: The memory byte address is the processor address shifted right by one. It is driven in the request cycle and held unchanged during the following busy cycle.
- R2: A byte read returns the upper stored nibble (bits 7:4) for an even address and the lower nibble (bits 3:0) for an odd address. The nibble appears on read data bits 3:0, with bits 15:4 zero. The result is valid, with `rd_valid` high, in the cycle after the request.
- R3: A word read returns the stored byte spread out as 0x0H0L: the upper nibble on bits 11:8, the lower nibble on bits 3:0, and all other bits zero.
- R4: A request with `cpu_wr` high raises `busy` for exactly one cycle, the cycle after the request. The memory write enable is high only in that cycle.
- R5: A byte write changes only the selected nibble and takes the new pixel from data bits 3:0. A word write takes the upper pixel from bits 11:8 and the lower pixel from bits 3:0. All other data bits are ignored.
- R6: Mode 0 (plain) always replaces the addressed nibble(s).
- R7: Mode 1 (underwrite), byte access: the nibble is written only when the stored nibble is zero and the new nibble is nonzero.
- R8: Mode 1 (underwrite), word access: each nibble is written only where the stored nibble is zero.
- R9: Mode 2 (overwrite): each addressed nibble is written only when its new value is nonzero. Otherwise the stored nibble is kept.
- R10: Mode 3 behaves exactly like mode 2.
- R11: Read or write strobes that arrive while `busy` is high are ignored.
- R12: After reset, `busy`, `rd_valid` and `ram_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | ADDR_W | Processor pixel address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_word | input | 1 | 1 = word access, 0 = byte access |
| cpu_rd | input | 1 | Read strobe, one cycle |
| cpu_wr | input | 1 | Write strobe, one cycle; wins over `cpu_rd` |
| wr_mode | input | 2 | Priority mode: 0 plain, 1 underwrite, 2 and 3 overwrite |
| cpu_rdata | output | 16 | Read data, valid while `rd_valid` is high |
| rd_valid | output | 1 | Read result valid |
| busy | output | 1 | Second cycle of an access |
| ram_addr | output | ADDR_W-1 | Memory byte address |
| ram_rdata | input | 8 | Memory read data, one cycle after the address |
| ram_wdata | output | 8 | Merged byte to write |
| ram_we | output | 1 | Memory write enable |

## Verification
Reads are tried at even and odd byte addresses and as words. This tells apart nibble selection, zero extension and the 0x0H0L spreading.

Writes are tried in every mode with both zero and nonzero values for the stored and the new nibbles. This separates each mode's conditions: underwrite against a filled pixel, overwrite with a transparent pixel, and mode 3 against mode 2.

Write data carries junk in its unused bits, to show that only the pixel fields are taken. A strobe issued during the busy cycle shows that such requests are dropped.

// File: rtl/nibble_pix_rmw.sv
module nibble_pix_rmw #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [15:0]       cpu_wdata,
  input  logic              cpu_word,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [1:0]        wr_mode,
  output logic [15:0]       cpu_rdata,
  output logic              rd_valid,
  output logic              busy,
  output logic [ADDR_W-2:0] ram_addr,
  input  logic [7:0]        ram_rdata,
  output logic [7:0]        ram_wdata,
  output logic              ram_we
);
  localparam int RAW = ADDR_W - 1;

  logic           busy_q, wr_q, word_q, odd_q;
  logic [1:0]     mode_q;
  logic [3:0]     nhi_q, nlo_q;
  logic [RAW-1:0] addr_q;
  logic           accept;

  assign accept = !busy_q && (cpu_rd || cpu_wr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      word_q <= 1'b0;
      odd_q  <= 1'b0;
      mode_q <= 2'd0;
      nhi_q  <= 4'd0;
      nlo_q  <= 4'd0;
      addr_q <= '0;
    end else begin
      busy_q <= accept;
      if (accept) begin
        wr_q   <= cpu_wr;
        word_q <= cpu_word;
        odd_q  <= cpu_addr[0];
        mode_q <= wr_mode;
        nhi_q  <= cpu_word ? cpu_wdata[11:8] : cpu_wdata[3:0];
        nlo_q  <= cpu_wdata[3:0];
        addr_q <= cpu_addr[ADDR_W-1:1];
      end
    end
  end

  function automatic logic [3:0] merge_nib(input logic [1:0] m, input logic byte_acc,
                                           input logic [3:0] old_n, input logic [3:0] new_n);
    case (m)
      2'd0:    merge_nib = new_n;
      2'd1:    merge_nib = (old_n == 4'd0 && (!byte_acc || new_n != 4'd0)) ? new_n : old_n;
      default: merge_nib = (new_n != 4'd0) ? new_n : old_n;
    endcase
  endfunction

  logic hi_sel, lo_sel;
  assign hi_sel = word_q || !odd_q;
  assign lo_sel = word_q ||  odd_q;

  assign ram_wdata[7:4] = hi_sel ? merge_nib(mode_q, !word_q, ram_rdata[7:4], nhi_q) : ram_rdata[7:4];
  assign ram_wdata[3:0] = lo_sel ? merge_nib(mode_q, !word_q, ram_rdata[3:0], nlo_q) : ram_rdata[3:0];

  assign ram_addr  = busy_q ? addr_q : cpu_addr[ADDR_W-1:1];
  assign ram_we    = busy_q && wr_q;
  assign rd_valid  = busy_q && !wr_q;
  assign busy      = busy_q;
  assign cpu_rdata = word_q ? {4'h0, ram_rdata[7:4], 4'h0, ram_rdata[3:0]}
                            : {12'h000, odd_q ? ram_rdata[3:0] : ram_rdata[7:4]};
endmodule

module nibble_pix_rmw_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [15:0]       cpu_wdata,
  input logic              cpu_word,
  input logic [1:0]        wr_mode,
  input logic [15:0]       cpu_rdata,
  input logic              rd_valid,
  input logic              busy,
  input logic [ADDR_W-2:0] ram_addr,
  input logic [7:0]        ram_rdata,
  input logic [7:0]        ram_wdata,
  input logic              ram_we
);
  assert_busy_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  assert_we_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> busy);
  assert_addr_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ram_addr == $past(cpu_addr[ADDR_W-1:1]));
  assert_byte_rd_zext_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !$past(cpu_word)) |-> cpu_rdata[15:4] == 12'h000);
  assert_word_rd_gaps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(cpu_word)) |-> (cpu_rdata[15:12] == 4'h0 && cpu_rdata[7:4] == 4'h0));
  assert_byte_other_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !$past(cpu_word)) |->
      ($past(cpu_addr[0]) ? ram_wdata[7:4] == ram_rdata[7:4] : ram_wdata[3:0] == ram_rdata[3:0]));
  assert_plain_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !$past(cpu_word) && $past(wr_mode) == 2'd0) |->
      ($past(cpu_addr[0]) ? ram_wdata[3:0] == $past(cpu_wdata[3:0])
                          : ram_wdata[7:4] == $past(cpu_wdata[3:0])));
  assert_no_rd_and_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && ram_we));
endmodule

bind nibble_pix_rmw nibble_pix_rmw_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_word(cpu_word), .wr_mode(wr_mode), .cpu_rdata(cpu_rdata),
  .rd_valid(rd_valid), .busy(busy), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
  .ram_wdata(ram_wdata), .ram_we(ram_we)
);

// File: tb/nibble_pix_rmw_tb.sv
module nibble_pix_rmw_tb_top;
  localparam int ADDR_W = 12;
  localparam int NV = 15;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [15:0]       cpu_wdata = '0;
  logic              cpu_word = 1'b0, cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [1:0]        wr_mode = 2'd0;
  logic [15:0]       cpu_rdata;
  logic              rd_valid, busy, ram_we;
  logic [ADDR_W-2:0] ram_addr;
  logic [7:0]        ram_rdata, ram_wdata;

  logic [7:0]        mem [0:(1<<(ADDR_W-1))-1];
  logic              ld_en = 1'b0;
  logic [ADDR_W-2:0] ld_addr = '0;
  logic [7:0]        ld_data = '0;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nibble_pix_rmw #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_word(cpu_word), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .wr_mode(wr_mode),
    .cpu_rdata(cpu_rdata), .rd_valid(rd_valid), .busy(busy), .ram_addr(ram_addr),
    .ram_rdata(ram_rdata), .ram_wdata(ram_wdata), .ram_we(ram_we)
  );

  always @(posedge clk) begin
    ram_rdata <= mem[ram_addr];
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (ld_en) mem[ld_addr] <= ld_data;
  end

  // {pre[7:0], addr[11:0], word, wr, mode[1:0], wdata[15:0], expected byte[7:0]}
  localparam logic [47:0] VEC [NV] = '{
    {8'hA5, 12'h020, 1'b0, 1'b0, 2'd0, 16'h0000, 8'hA5},
    {8'hA5, 12'h021, 1'b0, 1'b0, 2'd0, 16'h0000, 8'hA5},
    {8'h3C, 12'h030, 1'b1, 1'b0, 2'd0, 16'h0000, 8'h3C},
    {8'h5F, 12'h040, 1'b0, 1'b1, 2'd0, 16'hFFF7, 8'h7F},
    {8'h5F, 12'h041, 1'b0, 1'b1, 2'd0, 16'hABC0, 8'h50},
    {8'h12, 12'h050, 1'b1, 1'b1, 2'd0, 16'hF9E4, 8'h94},
    {8'h0B, 12'h060, 1'b0, 1'b1, 2'd1, 16'h0006, 8'h6B},
    {8'h2B, 12'h062, 1'b0, 1'b1, 2'd1, 16'h0006, 8'h2B},
    {8'h20, 12'h065, 1'b0, 1'b1, 2'd1, 16'h0000, 8'h20},
    {8'h0C, 12'h070, 1'b1, 1'b1, 2'd1, 16'h0507, 8'h5C},
    {8'h4D, 12'h081, 1'b0, 1'b1, 2'd2, 16'h00F0, 8'h4D},
    {8'h4D, 12'h083, 1'b0, 1'b1, 2'd2, 16'h0003, 8'h43},
    {8'h4D, 12'h090, 1'b1, 1'b1, 2'd2, 16'h0800, 8'h8D},
    {8'h4D, 12'h092, 1'b1, 1'b1, 2'd3, 16'h0009, 8'h49},
    {8'h4D, 12'h0A0, 1'b0, 1'b1, 2'd3, 16'h0000, 8'h4D}
  };

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic preload(input logic [ADDR_W-2:0] a, input logic [7:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R4: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !rd_valid && !ram_we, "R12", {13'd0, busy, rd_valid, ram_we}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rd_valid && !ram_we, "R12", {13'd0, busy, rd_valid, ram_we}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      logic [7:0]  pre, expb;
      logic [11:0] a;
      logic        w, wr;
      logic [15:0] exp_rd;
      pre = VEC[i][47:40]; a = VEC[i][39:28]; w = VEC[i][27]; wr = VEC[i][26];
      expb = VEC[i][7:0];
      preload(a[11:1], pre);
      @(negedge clk);
      cpu_addr = a; cpu_word = w; cpu_wr = wr; cpu_rd = !wr;
      wr_mode = VEC[i][25:24]; cpu_wdata = VEC[i][23:8];
      @(negedge clk);
      cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_addr = '1;
      chk(busy, "R4", {15'd0, busy}, 16'h1);
      chk(ram_addr == a[11:1], "R1", {5'd0, ram_addr}, {5'd0, a[11:1]});
      if (!wr) begin
        exp_rd = w ? {4'h0, pre[7:4], 4'h0, pre[3:0]} : {12'h0, a[0] ? pre[3:0] : pre[7:4]};
        chk(rd_valid && cpu_rdata == exp_rd, w ? "R3" : "R2", cpu_rdata, exp_rd);
        chk(!ram_we, "R4", {15'd0, ram_we}, 16'h0);
      end else begin
        chk(ram_we && !rd_valid, "R4", {14'd0, ram_we, rd_valid}, 16'h2);
      end
      @(negedge clk);
      chk(!busy && !ram_we, "R4", {14'd0, busy, ram_we}, 16'h0);
      case (i)
        3, 4:  chk(mem[a[11:1]] == expb, "R6", {8'd0, mem[a[11:1]]}, {8'd0, expb});
        5:     chk(mem[a[11:1]] == expb, "R5", {8'd0, mem[a[11:1]]}, {8'd0, expb});
        6, 7, 8: chk(mem[a[11:1]] == expb, "R7", {8'd0, mem[a[11:1]]}, {8'd0, expb});
        9:     chk(mem[a[11:1]] == expb, "R8", {8'd0, mem[a[11:1]]}, {8'd0, expb});
        10, 11, 12: chk(mem[a[11:1]] == expb, "R9", {8'd0, mem[a[11:1]]}, {8'd0, expb});
        13, 14: chk(mem[a[11:1]] == expb, "R10", {8'd0, mem[a[11:1]]}, {8'd0, expb});
        default: chk(mem[a[11:1]] == expb, "R2", {8'd0, mem[a[11:1]]}, {8'd0, expb});
      endcase
    end

    // R11: strobe during the busy cycle is dropped
    preload(11'h100, 8'h11);
    preload(11'h101, 8'h22);
    @(negedge clk);
    cpu_addr = 12'h200; cpu_word = 1'b1; cpu_wr = 1'b1; wr_mode = 2'd0; cpu_wdata = 16'h0A0B;
    @(negedge clk);
    cpu_addr = 12'h202; cpu_wdata = 16'h0C0D;
    @(negedge clk);
    cpu_wr = 1'b0;
    chk(!busy, "R11", {15'd0, busy}, 16'h0);
    @(negedge clk);
    chk(mem[11'h100] == 8'hAB, "R11", {8'd0, mem[11'h100]}, 16'h00AB);
    chk(mem[11'h101] == 8'h22, "R11", {8'd0, mem[11'h101]}, 16'h0022);

    // R5: byte write at odd address keeps the upper nibble, upper data bits ignored
    preload(11'h110, 8'h96);
    @(negedge clk);
    cpu_addr = 12'h221; cpu_word = 1'b0; cpu_wr = 1'b1; wr_mode = 2'd0; cpu_wdata = 16'hFF31;
    @(negedge clk);
    cpu_wr = 1'b0;
    @(negedge clk);
    chk(mem[11'h110] == 8'h91, "R5", {8'd0, mem[11'h110]}, 16'h0091);

    // R12: reset during an access clears busy
    @(negedge clk);
    cpu_addr = 12'h221; cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !rd_valid && !ram_we, "R12", {13'd0, busy, rd_valid, ram_we}, 16'h0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule